// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Bus Takeover

This block keeps a multi-bank DRAM array alive by refreshing one row at a time on a fixed schedule. A free-running interval timer divides the retention window (4 ms expressed in clock cycles) by the number of rows. Each time the timer expires, the block asks the processor for the shared memory bus, waits for the grant, then drives a refresh strobe with the current row address. Every bank refreshes that row in the same burst, so the number of refresh bursts per window depends only on the row count, never on how many banks are fitted.

A staggered mode lets the processor keep the bus. Banks are then refreshed one per cycle, and a bank that is busy with a processor access is passed over and tried again in a later cycle. When a new timer expiry arrives before the previous row has been finished in every bank, a sticky missed-deadline flag is raised and the late expiry is served right after the current one.

The bus request and grant form the block's only handshake. `bus_request` stays high from the expiry until the last strobe cycle, whatever the grant does. The processor holds `bus_grant` high until it sees the request fall. Memory behind a slow path lengthens each burst through the `wait_states` input.

Top module: `refresh_sequencer`

## Requirements
- R1: `bus_request` rises once every INTERVAL = WINDOW_CYCLES / 2^ROW_BITS cycles (rounded down), the first time INTERVAL cycles after reset is released, provided each refresh finishes within its interval.
- R2: Once raised, `bus_request` is held and no strobe is driven until `bus_grant` is sampled high at a clock edge. The strobe begins in the cycle after that edge.
- R3: In normal mode the strobe lasts exactly STROBE_CYCLES plus the value of `wait_states` sampled at the grant edge. Throughout the strobe `bank_sel` is all ones.
- R4: `bus_request` is low in the cycle right after the last strobe cycle, which returns the bus to the processor.
- R5: `row_addr` holds the row being refreshed during its strobe. It advances by one after each completed refresh and wraps from 2^ROW_BITS-1 to 0.
- R6: In staggered mode (`stagger_en` high when an expiry is taken) `bus_request` stays low. Each strobe cycle selects exactly one bank in `bank_sel` (bit i is bank i): the lowest-numbered bank still owed this row whose `bank_busy` bit is low. When every owed bank is busy, the strobe stays low. The row advances once all banks are done.
- R7: An expiry that arrives while a refresh is still in progress sets `deadline_miss`, which stays high until reset. The late refresh starts in the cycle after the current one ends.
- R8: Reset clears the timer, the row counter, any pending refresh and the miss flag, and leaves `bus_request`, `refresh_strobe` and `bank_sel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stagger_en | input | 1 | Selects staggered per-bank refresh for the next expiry taken |
| bus_grant | input | 1 | Processor grants the memory bus |
| wait_states | input | WAIT_W | Extra strobe cycles for slow memory, sampled at grant |
| bank_busy | input | BANKS | Per-bank processor access in progress |
| bus_request | output | 1 | Request for the memory bus |
| refresh_strobe | output | 1 | Refresh indication to the banks |
| row_addr | output | ROW_BITS | Row being refreshed |
| bank_sel | output | BANKS | Banks taking part in the current strobe cycle |
| deadline_miss | output | 1 | Sticky flag: an expiry arrived before the previous row was finished |

## Verification
The timer expiry and an unfinished refresh can land on the same clock edge. That edge must set the miss flag and also queue one more refresh. The bench provokes this in staggered mode by holding every bank busy across a full interval, then lets the banks go. It expects the flag to be high and to stay high. A scoreboard must then see two complete rows, each a run of four one-bank strobes in ascending bank order, with the second row following the first directly.

// File: rtl/refresh_seq_pkg.sv
package refresh_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_GNT = 2'd1,
    ST_BURST    = 2'd2,
    ST_STAGGER  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int INTERVAL = 781
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1: an expiry is followed by a full interval before the next one
  a_r1_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0) && !tick_o);
  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rfs_row_counter.sv
module rfs_row_counter #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     row_o <= '0;
    else if (adv_i) row_o <= row_o + 1'b1;
  end

  // R5: the row moves by exactly one per completed refresh, wrapping naturally
  a_r5_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> row_o == $past(row_o) + 1'b1);
  a_r5_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(row_o));
endmodule

// File: rtl/rfs_bank_picker.sv
module rfs_bank_picker #(
  parameter int BANKS = 4
) (
  input  logic [BANKS-1:0] owed_i,
  input  logic [BANKS-1:0] busy_i,
  output logic [BANKS-1:0] pick_o
);
  logic [BANKS-1:0] avail;
  logic [BANKS:0]   lower_taken;

  assign avail          = owed_i & ~busy_i;
  assign lower_taken[0] = 1'b0;

  for (genvar i = 0; i < BANKS; i++) begin : g_prio
    assign pick_o[i]        = avail[i] & ~lower_taken[i];
    assign lower_taken[i+1] = lower_taken[i] | avail[i];
  end

  // R6: never more than one bank, and never a busy one
  always_comb begin
    a_r6_pick_onehot: assert ($onehot0(pick_o));
    a_r6_pick_free:   assert ((pick_o & busy_i) == '0);
  end
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import refresh_seq_pkg::*;
#(
  parameter int WINDOW_CYCLES = 200000,
  parameter int ROW_BITS      = 8,
  parameter int BANKS         = 4,
  parameter int STROBE_CYCLES = 4,
  parameter int WAIT_W        = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stagger_en,
  input  logic                bus_grant,
  input  logic [WAIT_W-1:0]   wait_states,
  input  logic [BANKS-1:0]    bank_busy,
  output logic                bus_request,
  output logic                refresh_strobe,
  output logic [ROW_BITS-1:0] row_addr,
  output logic [BANKS-1:0]    bank_sel,
  output logic                deadline_miss
);
  localparam int ROWS     = 1 << ROW_BITS;
  localparam int INTERVAL = WINDOW_CYCLES / ROWS;
  localparam int CNT_W    = $clog2(STROBE_CYCLES + (1 << WAIT_W));

  seq_state_e       state_q;
  logic [CNT_W-1:0] burst_cnt_q;
  logic [BANKS-1:0] owed_q;
  logic             late_q;
  logic             miss_q;
  logic             tick;
  logic             start;
  logic             row_adv;
  logic [BANKS-1:0] stag_pick;
  logic [BANKS-1:0] owed_next;

  rfs_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  rfs_bank_picker #(.BANKS(BANKS)) u_picker (
    .owed_i (owed_q),
    .busy_i (bank_busy),
    .pick_o (stag_pick)
  );

  rfs_row_counter #(.ROW_W(ROW_BITS)) u_rows (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (row_adv),
    .row_o (row_addr)
  );

  assign owed_next = owed_q & ~stag_pick;
  assign start     = (state_q == ST_IDLE) && (tick || late_q);

  always_comb begin
    bus_request    = (state_q == ST_WAIT_GNT) || (state_q == ST_BURST);
    refresh_strobe = 1'b0;
    bank_sel       = '0;
    row_adv        = 1'b0;
    case (state_q)
      ST_BURST: begin
        refresh_strobe = 1'b1;
        bank_sel       = '1;
        row_adv        = (burst_cnt_q == '0);
      end
      ST_STAGGER: begin
        refresh_strobe = |stag_pick;
        bank_sel       = stag_pick;
        row_adv        = (owed_next == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      burst_cnt_q <= '0;
      owed_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          if (stagger_en) begin
            state_q <= ST_STAGGER;
            owed_q  <= '1;
          end else begin
            state_q <= ST_WAIT_GNT;
          end
        end
        ST_WAIT_GNT: if (bus_grant) begin
          state_q     <= ST_BURST;
          burst_cnt_q <= CNT_W'(STROBE_CYCLES - 1) + CNT_W'(wait_states);
        end
        ST_BURST: begin
          if (burst_cnt_q == '0) state_q <= ST_IDLE;
          else                   burst_cnt_q <= burst_cnt_q - 1'b1;
        end
        ST_STAGGER: begin
          owed_q <= owed_next;
          if (owed_next == '0) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      late_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      if (tick && state_q != ST_IDLE) begin
        late_q <= 1'b1;
        miss_q <= 1'b1;
      end else if (start) begin
        late_q <= 1'b0;
      end
    end
  end

  assign deadline_miss = miss_q;

  // R2: a normal-mode strobe starts only after the grant was seen
  a_r2_strobe_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(refresh_strobe) && bus_request) |-> $past(bus_grant));
  // R3: every bank takes part in a bus-owned strobe
  a_r3_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_strobe && bus_request) |-> (&bank_sel));
  // R4: the bus is handed back only right after a strobe
  a_r4_release_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_request) |-> $past(refresh_strobe));
  // R6: without the bus, at most one idle bank is touched per cycle
  a_r6_single_free_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_request |-> ($onehot0(bank_sel) && ((bank_sel & bank_busy) == '0)));
  // R7: once a deadline is missed the flag stays up
  a_r7_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    deadline_miss |=> deadline_miss);
endmodule

// File: tb/refresh_sequencer_tb.sv
module refresh_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WINDOW     = 320;
  localparam int RB         = 3;
  localparam int NB         = 4;
  localparam int STROBE     = 3;
  localparam int WW         = 3;
  localparam int INTERVAL   = WINDOW / (1 << RB);

  typedef struct {
    logic [RB-1:0] row;
    logic [NB-1:0] sel;
    int            len;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stagger_en = 1'b0;
  logic          bus_grant = 1'b0;
  logic [WW-1:0] wait_states = '0;
  logic [NB-1:0] bank_busy = '0;
  logic          bus_request;
  logic          refresh_strobe;
  logic [RB-1:0] row_addr;
  logic [NB-1:0] bank_sel;
  logic          deadline_miss;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  int prev_rise = 0;
  int run_len = 0;
  logic [RB-1:0] run_row = '0;
  logic [RB-1:0] exp_row = '0;
  bit finished = 0;
  item_t exp_q[$];

  refresh_sequencer #(
    .WINDOW_CYCLES(WINDOW), .ROW_BITS(RB), .BANKS(NB),
    .STROBE_CYCLES(STROBE), .WAIT_W(WW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .stagger_en(stagger_en), .bus_grant(bus_grant),
    .wait_states(wait_states), .bank_busy(bank_busy), .bus_request(bus_request),
    .refresh_strobe(refresh_strobe), .row_addr(row_addr), .bank_sel(bank_sel),
    .deadline_miss(deadline_miss)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(logic [RB-1:0] row, logic [NB-1:0] sel, int len);
    item_t it;
    it.row = row; it.sel = sel; it.len = len;
    exp_q.push_back(it);
  endtask

  task automatic emit(logic [RB-1:0] row, logic [NB-1:0] sel, int len);
    item_t it;
    if (exp_q.size() == 0) begin
      check(0, "R6 unexpected strobe", int'(sel), 0);
    end else begin
      it = exp_q.pop_front();
      check(row == it.row, "R5 strobe row", int'(row), int'(it.row));
      check(sel == it.sel, "R6 bank select", int'(sel), int'(it.sel));
      check(len == it.len, "R3 strobe length", len, it.len);
    end
  endtask

  // monitor: one item per staggered strobe cycle, one per normal burst
  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0;
    end else if (refresh_strobe && bank_sel != '1) begin
      emit(row_addr, bank_sel, 1);
    end else if (refresh_strobe) begin
      run_len++;
      run_row = row_addr;
    end else if (run_len > 0) begin
      emit(run_row, '1, run_len);
      run_len = 0;
    end
  end

  task automatic normal_refresh(int delay, int ws);
    int rise;
    @(posedge clk); #1 wait_states = WW'(ws);
    @(negedge clk);
    while (!bus_request) @(negedge clk);
    rise = cyc;
    check(rise - prev_rise == INTERVAL, "R1 request spacing", rise - prev_rise, INTERVAL);
    prev_rise = rise;
    push(exp_row, '1, STROBE + ws);
    repeat (delay) @(posedge clk);
    @(negedge clk);
    check(bus_request && !refresh_strobe, "R2 held without strobe before grant",
          int'(refresh_strobe), 0);
    @(posedge clk); #1 bus_grant = 1'b1;
    @(negedge clk);
    check(!refresh_strobe, "R2 no strobe in grant cycle", int'(refresh_strobe), 0);
    @(negedge clk);
    check(refresh_strobe, "R2 strobe after grant", int'(refresh_strobe), 1);
    while (refresh_strobe) @(negedge clk);
    check(!bus_request, "R4 bus released", int'(bus_request), 0);
    exp_row = exp_row + 1'b1;
    check(row_addr == exp_row, "R5 row advance", int'(row_addr), int'(exp_row));
    @(posedge clk); #1 bus_grant = 1'b0;
  endtask

  task automatic stag_refresh();
    int seen = 0;
    @(posedge clk); #1 bank_busy = 4'b0001;
    push(exp_row, 4'b0010, 1);
    push(exp_row, 4'b0100, 1);
    push(exp_row, 4'b1000, 1);
    push(exp_row, 4'b0001, 1);
    while (seen < 3) begin
      @(negedge clk);
      if (refresh_strobe) seen++;
      if (bus_request) check(0, "R6 request in staggered mode", 1, 0);
    end
    repeat (2) begin
      @(negedge clk);
      check(!refresh_strobe, "R6 busy bank skipped", int'(refresh_strobe), 0);
    end
    @(posedge clk); #1 bank_busy = '0;
    @(negedge clk);
    check(refresh_strobe && bank_sel == 4'b0001, "R6 retried bank", int'(bank_sel), 1);
    @(negedge clk);
    exp_row = exp_row + 1'b1;
    check(row_addr == exp_row, "R5 row after staggered", int'(row_addr), int'(exp_row));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "R1 watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!bus_request && !refresh_strobe && bank_sel == '0, "R8 outputs idle in reset",
          int'(bus_request), 0);
    check(row_addr == '0 && !deadline_miss, "R8 row and flag clear in reset",
          int'(row_addr), 0);
    rst_n = 1'b1;
    prev_rise = cyc;

    // ten normal refreshes, varied grant delay and wait states, wraps 7 -> 0
    for (int k = 0; k < 10; k++) normal_refresh(k % 6, (k * 3) % 8);
    check(!deadline_miss, "R7 no miss when on time", int'(deadline_miss), 0);

    @(posedge clk); #1 stagger_en = 1'b1;
    stag_refresh();
    stag_refresh();

    // expiry while all banks stay busy: miss plus one queued refresh
    @(posedge clk); #1 bank_busy = '1;
    for (int n = 0; n < 3 * INTERVAL && !deadline_miss; n++) @(negedge clk);
    check(deadline_miss, "R7 miss raised", int'(deadline_miss), 1);
    for (int b = 0; b < NB; b++) push(exp_row, NB'(1) << b, 1);
    for (int b = 0; b < NB; b++) push(exp_row + 1'b1, NB'(1) << b, 1);
    @(posedge clk); #1 bank_busy = '0;
    repeat (12) @(negedge clk);
    exp_row = exp_row + 2'd2;
    check(row_addr == exp_row, "R7 late row served", int'(row_addr), int'(exp_row));
    check(deadline_miss, "R7 miss sticky", int'(deadline_miss), 1);
    check(exp_q.size() == 0, "R7 all late strobes seen", exp_q.size(), 0);

    @(posedge clk); #1 rst_n = 1'b0; stagger_en = 1'b0;
    @(posedge clk); #1;
    check(!deadline_miss && row_addr == '0, "R8 reset clears flag and row",
          int'(row_addr), 0);
    check(!bus_request && !refresh_strobe, "R8 reset releases bus", int'(bus_request), 0);
    rst_n = 1'b1;
    prev_rise = cyc;
    exp_row = '0;
    normal_refresh(1, 2);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule